// File: doc/BRIEF.md
# Byte/Word Configurable Memory Bus Front End

This block sits between an asynchronous-style memory bus (active-low chip enable, output enable and write enable) and a 16-bit-wide storage array of 64K words. It turns the bus strobes into read and write cycles. It registers read data from the array and drives it back onto separate data-out and per-bit output-enable lines, which a pad ring combines into tristate pins. A run-time mode input chooses the bus width. In word mode all sixteen lines carry data. In byte mode the most significant data pin becomes an extra low-order address input that picks one half of the addressed word. That half is returned on the low eight lines, and the remaining upper lines are never driven.

Write cycles are not stored here. On the release of write enable while the chip is enabled, the block emits a one-clock command strobe that carries the latched address and the low data byte to a downstream command interpreter. A combinational decoder also reports which erase block the current address falls in. One 64 Kbyte end of the array holds a small main block, two parameter blocks and a boot block, and a parameter chooses whether that end is the top or the bottom of the array.

Top module: `bwbus_front`

## Requirements
- R1: When a clock edge samples chip enable low, output enable low, write enable high and the mode input high (word mode), then from that edge until the next edge dq_out equals the array word for the address sampled at that edge, and dq_oe is 16'hFFFF.
- R2: When such a read is sampled in byte mode (mode input low), dq_in[15] acts as the byte-select address bit. Value 0 returns bits 7:0 of the addressed word on dq_out[7:0], and value 1 returns bits 15:8 of that word on dq_out[7:0]. In both cases dq_oe[7:0] is 8'hFF.
- R3: After any edge that samples byte mode, dq_oe[15:8] is zero, so the upper seven data lines and the select pin are never driven.
- R4: After any edge that does not sample chip enable low together with output enable low and write enable high, dq_oe is all zero.
- R5: While chip enable is high, all other bus inputs are ignored. No output is enabled on the following cycle, and no command strobe is produced, even when write enable rises.
- R6: When a clock edge sees write enable high after it was low at the previous edge, with chip enable low, cmd_valid is 1 for the following cycle. cmd_data then holds dq_in[7:0], and cmd_addr holds the word address in bits 16:1 and, in bit 0, dq_in[15] in byte mode or 0 in word mode. Data bits 14:8 are discarded.
- R7: cmd_valid is never high on two consecutive cycles.
- R8: With TOP_BOOT=1, blk_idx is 0 for word addresses 0x0000–0x7FFF, 1 for 0x8000–0xBFFF (32 KB main), 2 for 0xC000–0xCFFF and 3 for 0xD000–0xDFFF (8 KB parameter blocks), and 4 for 0xE000–0xFFFF (16 KB boot).
- R9: With TOP_BOOT=0, blk_idx is 0 for 0x0000–0x1FFF (boot), 1 for 0x2000–0x2FFF, 2 for 0x3000–0x3FFF, 3 for 0x4000–0x7FFF (main) and 4 for 0x8000–0xFFFF.
- R10: While reset is asserted, dq_oe is zero and cmd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| addr | input | 16 | Word address |
| dq_in | input | 16 | Data pins as seen by the input buffers; bit 15 is the byte select in byte mode |
| dq_out | output | 16 | Read data toward the pads |
| dq_oe | output | 16 | Per-bit pad output enable |
| arr_addr | output | 16 | Word address to the storage array |
| arr_rdata | input | 16 | Word read from the storage array |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_addr | output | 17 | Byte-granular address of the command write |
| cmd_data | output | 8 | Command byte |
| blk_idx | output | 3 | Erase block number of addr, counted from the lowest address |

## Verification
The bench reads both bytes of words whose halves differ, so a swapped lane or a select bit taken from the wrong pin returns the wrong half. It runs every strobe combination that is not a read and checks that the lines float. A decoder that ignored write enable or chip enable would drive the bus during a write or while deselected. Command writes are sent in both widths with junk on bits 14:8, and one is sent with chip enable high. A strobe that stretched, that fired while deselected, or that leaked upper bits into the command would miscompare. Block numbers are checked on the first and last word of every block for both boot variants, so an off-by-one boundary or a mirrored parameter order shows up.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

   typedef enum logic [1:0] {
      BUS_IDLE  = 2'd0,
      BUS_READ  = 2'd1,
      BUS_WRITE = 2'd2
   } bus_cyc_e;

   // full-size blocks in the array plus the three extra pieces of the split end
   function automatic int unsigned n_blocks(input int unsigned addr_w, input int unsigned lg_full);
      return (32'd1 << (addr_w - lg_full)) + 32'd3;
   endfunction

endpackage

// File: rtl/bwb_blkmap.sv
module bwb_blkmap #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned LG_FULL  = 15,
   parameter bit          TOP_BOOT = 1'b1,
   parameter int unsigned BLK_W    = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [BLK_W-1:0]  idx
);
   localparam int unsigned SEG_W = ADDR_W - LG_FULL;
   localparam logic [SEG_W-1:0] SEG_LAST = '1;

   logic [SEG_W-1:0] seg;
   logic [2:0]       sub;
   logic             unused_low;

   assign seg        = addr[ADDR_W-1 -: SEG_W];
   assign sub        = addr[LG_FULL-1 -: 3];
   assign unused_low = ^addr[LG_FULL-4:0];

   generate
      if (TOP_BOOT) begin : g_top
         // split region is the highest segment: main, param A, param B, boot
         always_comb begin
            idx = BLK_W'(seg);
            if (seg == SEG_LAST && sub[2]) begin
               if (sub[1])      idx = BLK_W'(seg) + BLK_W'(3);
               else if (sub[0]) idx = BLK_W'(seg) + BLK_W'(2);
               else             idx = BLK_W'(seg) + BLK_W'(1);
            end
         end
      end else begin : g_bottom
         // split region is segment zero: boot, param A, param B, main
         always_comb begin
            idx = BLK_W'(seg) + BLK_W'(3);
            if (seg == '0) begin
               if (sub[2])       idx = BLK_W'(3);
               else if (!sub[1]) idx = BLK_W'(0);
               else if (sub[0])  idx = BLK_W'(2);
               else              idx = BLK_W'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bwb_rdpath.sv
module bwb_rdpath #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_go,
   input  logic              word_mode,
   input  logic              byte_hi,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] dq_out,
   output logic [DATA_W-1:0] dq_oe
);
   localparam int unsigned HALF = DATA_W / 2;

   logic              en_q;
   logic              wide_q;
   logic              hi_q;
   logic [DATA_W-1:0] data_q;
   logic [HALF-1:0]   lane;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         wide_q <= 1'b1;
         hi_q   <= 1'b0;
         data_q <= '1;
      end else begin
         en_q <= rd_go;
         if (rd_go) begin
            data_q <= rdata;
            wide_q <= word_mode;
            hi_q   <= byte_hi;
         end
      end
   end

   assign lane   = hi_q ? data_q[DATA_W-1:HALF] : data_q[HALF-1:0];
   assign dq_out = wide_q ? data_q : {{HALF{1'b0}}, lane};

   always_comb begin
      dq_oe = '0;
      if (en_q) dq_oe = wide_q ? {DATA_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
   end

   p_word_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_go && word_mode) |-> (dq_out == $past(rdata) && dq_oe == {DATA_W{1'b1}}));

   p_byte_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_go && !word_mode && byte_hi) |-> dq_out[HALF-1:0] == $past(rdata[DATA_W-1:HALF]));

   p_byte_lane_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_go && !word_mode && !byte_hi) |-> dq_out[HALF-1:0] == $past(rdata[HALF-1:0]));

   p_upper_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!word_mode) |-> dq_oe[DATA_W-1:HALF] == '0);

   p_idle_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_go) |-> dq_oe == '0);

endmodule

// File: rtl/bwb_cmdcap.sv
module bwb_cmdcap #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned HALF   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              word_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic              sel_pin,
   input  logic [HALF-1:0]   dq_low,
   output logic              cmd_valid,
   output logic [ADDR_W:0]   cmd_addr,
   output logic [HALF-1:0]   cmd_data
);
   logic we_q;
   logic wr_done;

   assign wr_done = !ce_n && we_n && !we_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q      <= 1'b1;
         cmd_valid <= 1'b0;
         cmd_addr  <= '0;
         cmd_data  <= '0;
      end else begin
         we_q      <= we_n;
         cmd_valid <= wr_done;
         if (wr_done) begin
            cmd_addr <= {addr, word_mode ? 1'b0 : sel_pin};
            cmd_data <= dq_low;
         end
      end
   end

   p_no_cmd_deselected_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ce_n) |-> !cmd_valid);

   p_strobe_on_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> ($past(we_n) && !$past(we_n, 2)));

   p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

endmodule

// File: rtl/bwbus_front.sv
module bwbus_front
   import bwb_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned LG_FULL  = 15,
   parameter bit          TOP_BOOT = 1'b1,
   localparam int unsigned BLK_W   = $clog2(n_blocks(ADDR_W, LG_FULL))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              word_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic [DATA_W-1:0] dq_oe,
   output logic [ADDR_W-1:0] arr_addr,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic              cmd_valid,
   output logic [ADDR_W:0]   cmd_addr,
   output logic [DATA_W/2-1:0] cmd_data,
   output logic [BLK_W-1:0]  blk_idx
);
   localparam int unsigned HALF  = DATA_W / 2;
   localparam int unsigned N_BLK = n_blocks(ADDR_W, LG_FULL);

   generate
      if (DATA_W % 2 != 0 || DATA_W < 4)
         $error("bwbus_front: DATA_W must be even and at least 4");
      if (LG_FULL < 3 || LG_FULL >= ADDR_W)
         $error("bwbus_front: LG_FULL must lie in [3, ADDR_W-1]");
   endgenerate

   bus_cyc_e cyc;
   logic     sel_pin;
   logic     unused_mid;

   always_comb begin
      cyc = BUS_IDLE;
      if (!ce_n) begin
         if (!we_n)      cyc = BUS_WRITE;
         else if (!oe_n) cyc = BUS_READ;
      end
   end

   assign sel_pin    = dq_in[DATA_W-1];
   assign unused_mid = ^dq_in[DATA_W-2:HALF];
   assign arr_addr   = addr;

   bwb_rdpath #(.DATA_W(DATA_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_go    (cyc == BUS_READ),
      .word_mode(word_mode),
      .byte_hi  (sel_pin),
      .rdata    (arr_rdata),
      .dq_out   (dq_out),
      .dq_oe    (dq_oe)
   );

   bwb_cmdcap #(.ADDR_W(ADDR_W), .HALF(HALF)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .we_n     (we_n),
      .word_mode(word_mode),
      .addr     (addr),
      .sel_pin  (sel_pin),
      .dq_low   (dq_in[HALF-1:0]),
      .cmd_valid(cmd_valid),
      .cmd_addr (cmd_addr),
      .cmd_data (cmd_data)
   );

   bwb_blkmap #(.ADDR_W(ADDR_W), .LG_FULL(LG_FULL), .TOP_BOOT(TOP_BOOT), .BLK_W(BLK_W)) u_map (
      .addr(addr),
      .idx (blk_idx)
   );

   p_blk_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      32'(blk_idx) < N_BLK);

   p_reset_quiet_r10: assert property (@(posedge clk)
      $past(!rst_n) |-> (dq_oe == '0 && !cmd_valid));

endmodule

// File: tb/bwbus_front_bench.sv
`timescale 1ns/1ps
module bwbus_front_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, word_mode = 1'b1;
   logic [15:0] addr = '0;
   logic [15:0] dq_in = '0;

   logic [15:0] dq_out, dq_oe, arr_addr, arr_rdata;
   logic        cmd_valid;
   logic [16:0] cmd_addr;
   logic [7:0]  cmd_data;
   logic [2:0]  blk_top;

   logic [15:0] b_out, b_oe, b_arr_addr, b_arr_rdata;
   logic        b_valid;
   logic [16:0] b_caddr;
   logic [7:0]  b_cdata;
   logic [2:0]  blk_bot;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [15:0] model(input logic [15:0] a);
      return (a * 16'h9E37) ^ 16'h5A0F;
   endfunction

   assign arr_rdata   = model(arr_addr);
   assign b_arr_rdata = model(b_arr_addr);

   bwbus_front #(.TOP_BOOT(1'b1)) u_bwbus_front (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .word_mode(word_mode), .addr(addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
      .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .blk_idx(blk_top)
   );

   bwbus_front #(.TOP_BOOT(1'b0)) u_bwbus_front_bot (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .word_mode(word_mode), .addr(addr), .dq_in(dq_in),
      .dq_out(b_out), .dq_oe(b_oe), .arr_addr(b_arr_addr), .arr_rdata(b_arr_rdata),
      .cmd_valid(b_valid), .cmd_addr(b_caddr), .cmd_data(b_cdata), .blk_idx(blk_bot)
   );

   typedef struct {
      int          due;
      bit          is_cmd;
      logic [15:0] e_out;
      logic [15:0] e_oe;
      bit          e_valid;
      logic [16:0] e_caddr;
      logic [7:0]  e_cdata;
      string       req;
   } item_t;

   item_t sbq[$];

   task automatic push_rd(input logic [15:0] eo, input logic [15:0] eoe, input string req);
      item_t it;
      it = '{due: cyc + 1, is_cmd: 1'b0, e_out: eo, e_oe: eoe, e_valid: 1'b0,
             e_caddr: '0, e_cdata: '0, req: req};
      sbq.push_back(it);
   endtask

   task automatic push_cmd(input bit v, input logic [16:0] ca, input logic [7:0] cd, input string req);
      item_t it;
      it = '{due: cyc + 1, is_cmd: 1'b1, e_out: '0, e_oe: '0, e_valid: v,
             e_caddr: ca, e_cdata: cd, req: req};
      sbq.push_back(it);
   endtask

   // monitor: compares every item that falls due in this cycle
   always @(negedge clk) begin
      while (sbq.size() > 0 && sbq[0].due == cyc) begin
         item_t it;
         it = sbq.pop_front();
         n_chk++;
         if (!it.is_cmd) begin
            if (dq_oe !== it.e_oe || (dq_out & it.e_oe) !== (it.e_out & it.e_oe)) begin
               n_bad++;
               $display("FAIL %s: out=%h oe=%h expected out=%h oe=%h",
                        it.req, dq_out & it.e_oe, dq_oe, it.e_out & it.e_oe, it.e_oe);
            end
         end else if (it.e_valid) begin
            if (cmd_valid !== 1'b1 || cmd_addr !== it.e_caddr || cmd_data !== it.e_cdata) begin
               n_bad++;
               $display("FAIL %s: valid=%b addr=%h data=%h expected valid=1 addr=%h data=%h",
                        it.req, cmd_valid, cmd_addr, cmd_data, it.e_caddr, it.e_cdata);
            end
         end else if (cmd_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: valid=%b expected valid=0", it.req, cmd_valid);
         end
      end
   end

   task automatic bus_read(input logic [15:0] a, input bit wide, input bit hi);
      logic [15:0] d;
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      word_mode = wide; addr = a;
      d = model(a);
      if (wide) begin
         dq_in = 16'h0000;
         push_rd(d, 16'hFFFF, "R1 word read");
      end else begin
         dq_in = {hi, 7'h55, 8'h00};   // bits 14:8 carry junk that must not matter
         push_rd({8'h00, hi ? d[15:8] : d[7:0]}, 16'h00FF, hi ? "R2 R3 byte read high" : "R2 R3 byte read low");
      end
   endtask

   task automatic bus_other(input logic c, input logic o, input logic w, input string req);
      @(negedge clk);
      ce_n = c; oe_n = o; we_n = w; addr = 16'h1234; word_mode = 1'b1;
      push_rd('0, 16'h0000, req);
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [15:0] d, input bit wide,
                            input bit c, input string req);
      @(negedge clk);
      ce_n = c; oe_n = 1'b0; we_n = 1'b0; word_mode = wide; addr = a; dq_in = d;
      push_rd('0, 16'h0000, "R4 no drive during write");
      @(negedge clk);
      we_n = 1'b1;
      push_cmd(!c, {a, wide ? 1'b0 : d[15]}, d[7:0], req);
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
      push_cmd(1'b0, '0, '0, "R7 strobe lasts one cycle");
   endtask

   function automatic logic [2:0] exp_top(input logic [15:0] a);
      if (a < 16'h8000) return 3'd0;
      if (a < 16'hC000) return 3'd1;
      if (a < 16'hD000) return 3'd2;
      if (a < 16'hE000) return 3'd3;
      return 3'd4;
   endfunction

   function automatic logic [2:0] exp_bot(input logic [15:0] a);
      if (a < 16'h2000) return 3'd0;
      if (a < 16'h3000) return 3'd1;
      if (a < 16'h4000) return 3'd2;
      if (a < 16'h8000) return 3'd3;
      return 3'd4;
   endfunction

   localparam logic [15:0] BND [16] = '{16'h0000, 16'h1FFF, 16'h2000, 16'h2FFF,
                                        16'h3000, 16'h3FFF, 16'h4000, 16'h7FFF,
                                        16'h8000, 16'hBFFF, 16'hC000, 16'hCFFF,
                                        16'hD000, 16'hDFFF, 16'hE000, 16'hFFFF};

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;   // R10 reset state
      if (dq_oe !== 16'h0000 || cmd_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R10: oe=%h valid=%b expected oe=0000 valid=0", dq_oe, cmd_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);

      bus_read(16'h0001, 1'b1, 1'b0);
      bus_read(16'hBEEF, 1'b1, 1'b0);
      bus_read(16'h7FFF, 1'b0, 1'b0);
      bus_read(16'h7FFF, 1'b0, 1'b1);
      bus_read(16'h4321, 1'b0, 1'b1);
      bus_read(16'h4321, 1'b1, 1'b0);
      bus_read(16'hC0DE, 1'b0, 1'b0);
      bus_read(16'hFFFF, 1'b1, 1'b0);

      bus_other(1'b0, 1'b1, 1'b1, "R4 output enable high");
      bus_other(1'b0, 1'b0, 1'b0, "R4 write enable low");
      bus_other(1'b1, 1'b0, 1'b1, "R5 chip deselected");
      bus_other(1'b1, 1'b1, 1'b1, "R4 all strobes high");

      bus_write(16'h5555, 16'h7FAA, 1'b1, 1'b0, "R6 word-mode command");
      bus_write(16'h2AAA, 16'hFF55, 1'b0, 1'b0, "R6 byte-mode command select high");
      bus_write(16'h0ABC, 16'h6390, 1'b0, 1'b0, "R6 byte-mode command select low");
      bus_write(16'h1111, 16'h00F0, 1'b1, 1'b1, "R5 write while deselected");
      bus_read(16'h5555, 1'b1, 1'b0);

      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      repeat (3) @(negedge clk);

      foreach (BND[i]) begin
         @(negedge clk);
         addr = BND[i];
         #1;
         n_chk++;
         if (blk_top !== exp_top(BND[i])) begin
            n_bad++;
            $display("FAIL R8: addr=%h idx=%0d expected %0d", BND[i], blk_top, exp_top(BND[i]));
         end
         n_chk++;
         if (blk_bot !== exp_bot(BND[i])) begin
            n_bad++;
            $display("FAIL R9: addr=%h idx=%0d expected %0d", BND[i], blk_bot, exp_bot(BND[i]));
         end
      end

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule